// File: doc/BRIEF.md
# Fetch Group Former

This block turns one buffered instruction-cache line plus a thread's current PC and next-PC into a group of fixed 4-byte instructions for decode, all in one cycle. It keeps a single line buffer with its block-aligned address. A fetch whose PC falls in that block is served from the buffer. Any other fetch produces a cache request for the aligned block and no instructions. A fetch that arrives with a translation fault produces one no-op slot that carries a fault flag.

Inside a group, each slot records its instruction word, its PC, the predicted PC and next-PC that follow it, and whether the predictor called it taken. Which words are control instructions, and the predictor's taken bit and target for each word, arrive as per-word vectors indexed by word position in the line. A group stops at the fetch width, at the end of the line, or right after an instruction whose predicted PC is not its own PC plus 4. The updated PC and next-PC for the thread are returned with the group. A mode input selects branch-delay-slot next-PC semantics.

Top module: `fetch_group_former`

## Requirements
- R1: After reset, `outValid`, `cacheReq`, `faultOut` and `slotValid` are 0, `slotCount` is 0, `newPc`/`newNpc` are 0, and no line is held, so the first fetch misses.
- R2: All results are registered. They appear one clock edge after the edge that samples `fetchValid` high. `outValid` is high for exactly the cycles that follow a sampled `fetchValid`.
- R3: A fault-free fetch whose block-aligned PC (PC with its low log2(LINE_BYTES) bits cleared) does not match the buffered line's address, or arrives when no line is held, raises `cacheReq` with `cacheReqAddr` equal to that aligned address, emits 0 slots, and returns `newPc`/`newNpc` equal to the fetch PC and next-PC.
- R4: A `fillValid` cycle loads `fillData` and the aligned `fillAddr` into the buffer. A later fetch in the same block forms a group with no `cacheReq`.
- R5: The first slot holds line word floor((PC mod LINE_BYTES)/4). Byte 0 of the line sits in `fillData[31:0]`, and word k sits at bits [32k+31:32k]. The first slot's PC is the fetch PC.
- R6: A group holds at most WIDTH slots.
- R7: A group never crosses the end of the line. The last slot it can hold is word LINE_BYTES/4-1.
- R8: A non-control slot predicts PC = next-PC and next-PC = next-PC+4, not taken.
- R9: With `delayMode`=0, a control slot predicts PC = target if taken and PC+4 if not, and next-PC = predicted PC+4.
- R10: With `delayMode`=1, a control slot predicts PC = its incoming next-PC, and next-PC = target if taken or incoming next-PC+4 if not.
- R11: A slot whose predicted PC differs from its own PC+4 is emitted and is the last slot of the group. The returned `newPc`/`newNpc` equal the last slot's predictions.
- R12: A faulting fetch emits exactly one slot with instruction NOP_INST (default 32'h00000013) and `faultOut`=1, and returns `newPc`/`newNpc` equal to the fetch PC and next-PC. A fault takes priority over a miss.
- R13: `slotCount` equals the number of valid slots, and the valid slots are contiguous from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Load a line into the buffer |
| fillAddr | input | AW | Address of the filled line |
| fillData | input | LINE_BYTES*8 | Filled line contents, byte 0 in the low bits |
| fetchValid | input | 1 | Fetch request this cycle |
| fetchPc | input | AW | Thread PC |
| fetchNpc | input | AW | Thread next-PC |
| fetchFault | input | 1 | Translation fault for this fetch |
| delayMode | input | 1 | 1 selects branch-delay-slot semantics |
| ctrlMask | input | LINE_BYTES/4 | Per-word control-instruction flag |
| takenMask | input | LINE_BYTES/4 | Per-word predicted-taken flag |
| targetVec | input | LINE_BYTES/4*AW | Per-word predicted target |
| outValid | output | 1 | Result valid |
| cacheReq | output | 1 | Line miss: request the block |
| cacheReqAddr | output | AW | Block-aligned address requested |
| slotValid | output | WIDTH | Per-slot valid |
| slotInst | output | WIDTH*32 | Per-slot instruction word |
| slotPc | output | WIDTH*AW | Per-slot PC |
| slotPredPc | output | WIDTH*AW | Per-slot predicted PC |
| slotPredNpc | output | WIDTH*AW | Per-slot predicted next-PC |
| slotTaken | output | WIDTH | Per-slot predicted taken |
| slotCount | output | $clog2(WIDTH+1) | Slots emitted this cycle |
| faultOut | output | 1 | Fault slot emitted |
| newPc | output | AW | Updated thread PC |
| newNpc | output | AW | Updated thread next-PC |

## Verification
Every result of a fetch, whether a group, a miss request or a fault slot, is due exactly one clock edge after the edge that samples the request. A line fill is visible to a fetch sampled on any later edge. The bench changes inputs on the falling edge, holds a request for one rising edge, and reads every output at the next falling edge. That is the half-cycle after the result register loads and before the register is cleared by the idle cycle that follows. One idle cycle checks that `outValid` drops again.

// File: rtl/fgf_pkg.sv
package fgf_pkg;

  localparam int INST_BYTES = 4;
  localparam int INST_BITS  = 32;

  typedef struct packed {
    logic loadLine;   // capture the fill into the line buffer
    logic formGroup;  // buffered line hit: build a group
    logic emitFault;  // translation fault: single no-op slot
    logic issueMiss;  // line miss: request the block
  } fgStrobes_t;

endpackage

// File: rtl/fg_control.sv
module fg_control
  import fgf_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fillValid,
  input  logic [AW-1:0] fillAddr,
  input  logic          fetchValid,
  input  logic [AW-1:0] fetchPc,
  input  logic          fetchFault,
  output fgStrobes_t    strb,
  output logic          outValid,
  output logic          cacheReq,
  output logic [AW-1:0] cacheReqAddr
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  logic [AW-1:0] tagQ;
  logic          tagValidQ;
  logic [AW-1:0] fetchBlock;
  logic [AW-1:0] fillBlock;
  logic          lineHit;

  assign fetchBlock = {fetchPc[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign fillBlock  = {fillAddr[AW-1:OFF_W], {OFF_W{1'b0}}};
  assign lineHit    = tagValidQ && (tagQ == fetchBlock);

  always_comb begin
    strb.loadLine  = fillValid;
    strb.emitFault = fetchValid && fetchFault;
    strb.formGroup = fetchValid && !fetchFault && lineHit;
    strb.issueMiss = fetchValid && !fetchFault && !lineHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ         <= '0;
      tagValidQ    <= 1'b0;
      outValid     <= 1'b0;
      cacheReq     <= 1'b0;
      cacheReqAddr <= '0;
    end else begin
      if (strb.loadLine) begin
        tagQ      <= fillBlock;
        tagValidQ <= 1'b1;
      end
      outValid     <= fetchValid;
      cacheReq     <= strb.issueMiss;
      cacheReqAddr <= strb.issueMiss ? fetchBlock : '0;
    end
  end

endmodule

// File: rtl/fg_datapath.sv
module fg_datapath
  import fgf_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          WIDTH      = 4,
  parameter logic [31:0] NOP_INST   = 32'h0000_0013
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  fgStrobes_t                     strb,
  input  logic [LINE_BYTES*8-1:0]        fillData,
  input  logic [AW-1:0]                  fetchPc,
  input  logic [AW-1:0]                  fetchNpc,
  input  logic                           delayMode,
  input  logic [LINE_BYTES/4-1:0]        ctrlMask,
  input  logic [LINE_BYTES/4-1:0]        takenMask,
  input  logic [LINE_BYTES/4*AW-1:0]     targetVec,
  output logic [WIDTH-1:0]               slotValid,
  output logic [WIDTH*INST_BITS-1:0]     slotInst,
  output logic [WIDTH*AW-1:0]            slotPc,
  output logic [WIDTH*AW-1:0]            slotPredPc,
  output logic [WIDTH*AW-1:0]            slotPredNpc,
  output logic [WIDTH-1:0]               slotTaken,
  output logic [$clog2(WIDTH+1)-1:0]     slotCount,
  output logic                           faultOut,
  output logic [AW-1:0]                  newPc,
  output logic [AW-1:0]                  newNpc
);

  localparam int WORDS  = LINE_BYTES / INST_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int CNT_W  = $clog2(WIDTH + 1);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic [LINE_BYTES*8-1:0] lineQ;

  // combinational group
  logic [WIDTH-1:0]           gValid;
  logic [WIDTH*INST_BITS-1:0] gInst;
  logic [WIDTH*AW-1:0]        gPc;
  logic [WIDTH*AW-1:0]        gPredPc;
  logic [WIDTH*AW-1:0]        gPredNpc;
  logic [WIDTH-1:0]           gTaken;
  logic [CNT_W-1:0]           gCount;
  logic [AW-1:0]              gEndPc;
  logic [AW-1:0]              gEndNpc;

  always_comb begin
    logic [AW-1:0]    curPc;
    logic [AW-1:0]    curNpc;
    logic [AW-1:0]    nxtPc;
    logic [AW-1:0]    nxtNpc;
    logic [AW-1:0]    tgt;
    logic [OFF_W:0]   off;
    logic [WORD_W-1:0] wIdx;
    logic             keepGoing;
    logic             isTaken;

    curPc     = fetchPc;
    curNpc    = fetchNpc;
    off       = {1'b0, fetchPc[OFF_W-1:2], 2'b00};
    keepGoing = 1'b1;
    gValid    = '0;
    gInst     = '0;
    gPc       = '0;
    gPredPc   = '0;
    gPredNpc  = '0;
    gTaken    = '0;
    gCount    = '0;
    nxtPc     = '0;
    nxtNpc    = '0;
    tgt       = '0;
    wIdx      = '0;
    isTaken   = 1'b0;

    for (int i = 0; i < WIDTH; i++) begin
      if (keepGoing && !off[OFF_W]) begin
        wIdx = WORD_W'(off[OFF_W-1:2]);
        tgt  = targetVec[wIdx*AW +: AW];
        if (!ctrlMask[wIdx]) begin
          isTaken = 1'b0;
          nxtPc   = curNpc;
          nxtNpc  = curNpc + STEP;
        end else begin
          isTaken = takenMask[wIdx];
          if (delayMode) begin
            nxtPc  = curNpc;
            nxtNpc = isTaken ? tgt : (curNpc + STEP);
          end else begin
            nxtPc  = isTaken ? tgt : (curPc + STEP);
            nxtNpc = nxtPc + STEP;
          end
        end
        gValid[i]                     = 1'b1;
        gInst[i*INST_BITS +: INST_BITS] = lineQ[wIdx*INST_BITS +: INST_BITS];
        gPc[i*AW +: AW]               = curPc;
        gPredPc[i*AW +: AW]           = nxtPc;
        gPredNpc[i*AW +: AW]          = nxtNpc;
        gTaken[i]                     = isTaken;
        gCount                        = gCount + 1'b1;
        if (nxtPc != curPc + STEP) keepGoing = 1'b0;
        curPc  = nxtPc;
        curNpc = nxtNpc;
        off    = off + (OFF_W+1)'(INST_BYTES);
      end
    end
    gEndPc  = curPc;
    gEndNpc = curNpc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineQ <= '0;
    end else if (strb.loadLine) begin
      lineQ <= fillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid   <= '0;
      slotInst    <= '0;
      slotPc      <= '0;
      slotPredPc  <= '0;
      slotPredNpc <= '0;
      slotTaken   <= '0;
      slotCount   <= '0;
      faultOut    <= 1'b0;
      newPc       <= '0;
      newNpc      <= '0;
    end else if (strb.emitFault) begin
      slotValid   <= WIDTH'(1);
      slotInst    <= (WIDTH*INST_BITS)'(NOP_INST);
      slotPc      <= (WIDTH*AW)'(fetchPc);
      slotPredPc  <= (WIDTH*AW)'(fetchPc);
      slotPredNpc <= (WIDTH*AW)'(fetchNpc);
      slotTaken   <= '0;
      slotCount   <= CNT_W'(1);
      faultOut    <= 1'b1;
      newPc       <= fetchPc;
      newNpc      <= fetchNpc;
    end else if (strb.formGroup) begin
      slotValid   <= gValid;
      slotInst    <= gInst;
      slotPc      <= gPc;
      slotPredPc  <= gPredPc;
      slotPredNpc <= gPredNpc;
      slotTaken   <= gTaken;
      slotCount   <= gCount;
      faultOut    <= 1'b0;
      newPc       <= gEndPc;
      newNpc      <= gEndNpc;
    end else if (strb.issueMiss) begin
      slotValid   <= '0;
      slotTaken   <= '0;
      slotCount   <= '0;
      faultOut    <= 1'b0;
      newPc       <= fetchPc;
      newNpc      <= fetchNpc;
    end else begin
      slotValid   <= '0;
      slotTaken   <= '0;
      slotCount   <= '0;
      faultOut    <= 1'b0;
    end
  end

endmodule

// File: rtl/fetch_group_former.sv
module fetch_group_former
  import fgf_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          LINE_BYTES = 32,
  parameter int          WIDTH      = 4,
  parameter logic [31:0] NOP_INST   = 32'h0000_0013
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fillValid,
  input  logic [AW-1:0]                fillAddr,
  input  logic [LINE_BYTES*8-1:0]      fillData,
  input  logic                         fetchValid,
  input  logic [AW-1:0]                fetchPc,
  input  logic [AW-1:0]                fetchNpc,
  input  logic                         fetchFault,
  input  logic                         delayMode,
  input  logic [LINE_BYTES/4-1:0]      ctrlMask,
  input  logic [LINE_BYTES/4-1:0]      takenMask,
  input  logic [LINE_BYTES/4*AW-1:0]   targetVec,
  output logic                         outValid,
  output logic                         cacheReq,
  output logic [AW-1:0]                cacheReqAddr,
  output logic [WIDTH-1:0]             slotValid,
  output logic [WIDTH*32-1:0]          slotInst,
  output logic [WIDTH*AW-1:0]          slotPc,
  output logic [WIDTH*AW-1:0]          slotPredPc,
  output logic [WIDTH*AW-1:0]          slotPredNpc,
  output logic [WIDTH-1:0]             slotTaken,
  output logic [$clog2(WIDTH+1)-1:0]   slotCount,
  output logic                         faultOut,
  output logic [AW-1:0]                newPc,
  output logic [AW-1:0]                newNpc
);

  fgStrobes_t strb;

  fg_control #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_control (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillAddr(fillAddr),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .fetchFault(fetchFault),
    .strb(strb), .outValid(outValid),
    .cacheReq(cacheReq), .cacheReqAddr(cacheReqAddr)
  );

  fg_datapath #(.AW(AW), .LINE_BYTES(LINE_BYTES), .WIDTH(WIDTH), .NOP_INST(NOP_INST)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .fillData(fillData),
    .fetchPc(fetchPc), .fetchNpc(fetchNpc), .delayMode(delayMode),
    .ctrlMask(ctrlMask), .takenMask(takenMask), .targetVec(targetVec),
    .slotValid(slotValid), .slotInst(slotInst), .slotPc(slotPc),
    .slotPredPc(slotPredPc), .slotPredNpc(slotPredNpc), .slotTaken(slotTaken),
    .slotCount(slotCount), .faultOut(faultOut), .newPc(newPc), .newNpc(newNpc)
  );

endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 32,
  parameter int WIDTH      = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       fetchValid,
  input logic [AW-1:0]              fetchPc,
  input logic                       fetchFault,
  input logic                       outValid,
  input logic                       cacheReq,
  input logic [AW-1:0]              cacheReqAddr,
  input logic [WIDTH-1:0]           slotValid,
  input logic [WIDTH*AW-1:0]        slotPc,
  input logic [$clog2(WIDTH+1)-1:0] slotCount,
  input logic                       faultOut,
  input logic [AW-1:0]              newPc
);

  localparam int OFF_W = $clog2(LINE_BYTES);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> outValid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !fetchValid |=> (!outValid && !cacheReq && !faultOut && slotCount == 0));

  a_r3_miss_empty: assert property (@(posedge clk) disable iff (!rstN)
    cacheReq |-> (slotCount == 0 && !faultOut && cacheReqAddr[OFF_W-1:0] == '0));

  a_r6_width_bound: assert property (@(posedge clk) disable iff (!rstN)
    slotCount <= WIDTH);

  a_r12_fault_slot: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchFault) |=> (faultOut && !cacheReq && slotCount == 1 && newPc == $past(fetchPc)));

  a_r13_count_match: assert property (@(posedge clk) disable iff (!rstN)
    $countones(slotValid) == slotCount);

  a_r13_first_slot: assert property (@(posedge clk) disable iff (!rstN)
    (slotCount != 0) |-> slotValid[0]);

  a_r5_first_pc: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && !fetchFault) |=> (cacheReq || slotPc[AW-1:0] == $past(fetchPc)));

endmodule

bind fetch_group_former fg_checker #(.AW(AW), .LINE_BYTES(LINE_BYTES), .WIDTH(WIDTH)) u_fg_checker (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
  .fetchFault(fetchFault), .outValid(outValid), .cacheReq(cacheReq),
  .cacheReqAddr(cacheReqAddr), .slotValid(slotValid), .slotPc(slotPc),
  .slotCount(slotCount), .faultOut(faultOut), .newPc(newPc)
);

// File: tb/fetch_group_former_bench.sv
`timescale 1ns/1ps
module fetch_group_former_bench;

  localparam int AW    = 32;
  localparam int LB    = 32;
  localparam int WORDS = LB / 4;
  localparam int WIDTH = 4;
  localparam int CW    = $clog2(WIDTH + 1);
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillValid = 1'b0;
  logic [AW-1:0] fillAddr = '0;
  logic [LB*8-1:0] fillData = '0;
  logic fetchValid = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic [AW-1:0] fetchNpc = '0;
  logic fetchFault = 1'b0;
  logic delayMode = 1'b0;
  logic [WORDS-1:0] ctrlMask = '0;
  logic [WORDS-1:0] takenMask = '0;
  logic [WORDS*AW-1:0] targetVec = '0;
  logic outValid, cacheReq, faultOut;
  logic [AW-1:0] cacheReqAddr, newPc, newNpc;
  logic [WIDTH-1:0] slotValid, slotTaken;
  logic [WIDTH*32-1:0] slotInst;
  logic [WIDTH*AW-1:0] slotPc, slotPredPc, slotPredNpc;
  logic [CW-1:0] slotCount;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fetch_group_former #(.AW(AW), .LINE_BYTES(LB), .WIDTH(WIDTH), .NOP_INST(NOP)) u_fetch_group_former (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .fillAddr(fillAddr),
    .fillData(fillData), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .fetchNpc(fetchNpc), .fetchFault(fetchFault), .delayMode(delayMode),
    .ctrlMask(ctrlMask), .takenMask(takenMask), .targetVec(targetVec),
    .outValid(outValid), .cacheReq(cacheReq), .cacheReqAddr(cacheReqAddr),
    .slotValid(slotValid), .slotInst(slotInst), .slotPc(slotPc),
    .slotPredPc(slotPredPc), .slotPredNpc(slotPredNpc), .slotTaken(slotTaken),
    .slotCount(slotCount), .faultOut(faultOut), .newPc(newPc), .newNpc(newNpc)
  );

  function automatic logic [31:0] lineWord(int k);
    return 32'h1000_0000 + 32'(k) * 32'h0000_0111;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic doFetch(input logic [AW-1:0] pc, input logic [AW-1:0] npc, input bit flt);
    @(negedge clk);
    fetchPc = pc; fetchNpc = npc; fetchFault = flt; fetchValid = 1'b1;
    @(negedge clk);
    fetchValid = 1'b0; fetchFault = 1'b0;
  endtask

  task automatic setBranch(input int w, input bit tk, input logic [AW-1:0] tgt);
    ctrlMask = '0; takenMask = '0; targetVec = '0;
    ctrlMask[w] = 1'b1; takenMask[w] = tk; targetVec[w*AW +: AW] = tgt;
  endtask

  task automatic clearBranch();
    ctrlMask = '0; takenMask = '0; targetVec = '0;
  endtask

  task automatic testReset();
    checkEq("R1", "outValid", 64'(outValid), 0);
    checkEq("R1", "cacheReq", 64'(cacheReq), 0);
    checkEq("R1", "slotCount", 64'(slotCount), 0);
    checkEq("R1", "newPc", 64'(newPc), 0);
    checkEq("R1", "slotValid", 64'(slotValid), 0);
  endtask

  task automatic testColdMiss();
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R2", "outValid after fetch", 64'(outValid), 1);
    checkEq("R3", "cold cacheReq", 64'(cacheReq), 1);
    checkEq("R3", "cold reqAddr", 64'(cacheReqAddr), 64'h100);
    checkEq("R3", "cold slotCount", 64'(slotCount), 0);
    checkEq("R3", "cold newPc", 64'(newPc), 64'h100);
    @(negedge clk);
    checkEq("R2", "outValid idle", 64'(outValid), 0);
  endtask

  task automatic doFill();
    @(negedge clk);
    fillValid = 1'b1; fillAddr = 32'h104;
    for (int k = 0; k < WORDS; k++) fillData[k*32 +: 32] = lineWord(k);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic testSequential();
    clearBranch(); delayMode = 1'b0;
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R4", "hit no cacheReq", 64'(cacheReq), 0);
    checkEq("R6", "width-limited count", 64'(slotCount), 4);
    checkEq("R8", "newPc", 64'(newPc), 64'h110);
    checkEq("R8", "newNpc", 64'(newNpc), 64'h114);
    checkEq("R8", "slot2 predPc", 64'(slotPredPc[2*AW +: AW]), 64'h10C);
    checkEq("R13", "slotValid", 64'(slotValid), 64'hF);
    checkEq("R5", "slot3 inst", 64'(slotInst[3*32 +: 32]), 64'(lineWord(3)));
  endtask

  task automatic testLineEnd();
    clearBranch();
    doFetch(32'h114, 32'h118, 1'b0);
    checkEq("R7", "line-end count", 64'(slotCount), 3);
    checkEq("R7", "line-end newPc", 64'(newPc), 64'h120);
    checkEq("R7", "line-end newNpc", 64'(newNpc), 64'h124);
    checkEq("R13", "line-end slotValid", 64'(slotValid), 64'h7);
    checkEq("R7", "last inst", 64'(slotInst[2*32 +: 32]), 64'(lineWord(7)));
  endtask

  task automatic testOffset();
    clearBranch();
    doFetch(32'h109, 32'h10D, 1'b0);
    checkEq("R5", "slot0 inst word2", 64'(slotInst[31:0]), 64'(lineWord(2)));
    checkEq("R5", "slot0 pc", 64'(slotPc[AW-1:0]), 64'h109);
    checkEq("R5", "offset count", 64'(slotCount), 4);
    checkEq("R8", "offset newPc", 64'(newPc), 64'h119);
  endtask

  task automatic testTakenNoDelay();
    setBranch(1, 1'b1, 32'h200); delayMode = 1'b0;
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R11", "taken count", 64'(slotCount), 2);
    checkEq("R9", "slot1 predPc", 64'(slotPredPc[AW +: AW]), 64'h200);
    checkEq("R9", "slot1 predNpc", 64'(slotPredNpc[AW +: AW]), 64'h204);
    checkEq("R9", "slot1 taken", 64'(slotTaken), 64'h2);
    checkEq("R11", "taken newPc", 64'(newPc), 64'h200);
    checkEq("R11", "taken newNpc", 64'(newNpc), 64'h204);
  endtask

  task automatic testNotTaken();
    setBranch(1, 1'b0, 32'h200); delayMode = 1'b0;
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R9", "not-taken count", 64'(slotCount), 4);
    checkEq("R9", "not-taken slot1 predPc", 64'(slotPredPc[AW +: AW]), 64'h108);
    checkEq("R9", "not-taken flags", 64'(slotTaken), 0);
    checkEq("R9", "not-taken newPc", 64'(newPc), 64'h110);
  endtask

  task automatic testDelaySlot();
    setBranch(1, 1'b1, 32'h200); delayMode = 1'b1;
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R10", "delay count", 64'(slotCount), 3);
    checkEq("R10", "ctrl predPc", 64'(slotPredPc[AW +: AW]), 64'h108);
    checkEq("R10", "ctrl predNpc", 64'(slotPredNpc[AW +: AW]), 64'h200);
    checkEq("R11", "delay slot predPc", 64'(slotPredPc[2*AW +: AW]), 64'h200);
    checkEq("R10", "delay newPc", 64'(newPc), 64'h200);
    checkEq("R10", "delay newNpc", 64'(newNpc), 64'h204);
    // branch in the last slot: delay slot carried into the next group
    setBranch(3, 1'b1, 32'h200);
    doFetch(32'h100, 32'h104, 1'b0);
    checkEq("R10", "edge count", 64'(slotCount), 4);
    checkEq("R10", "edge newPc", 64'(newPc), 64'h110);
    checkEq("R10", "edge newNpc", 64'(newNpc), 64'h200);
    clearBranch();
    doFetch(32'h110, 32'h200, 1'b0);
    checkEq("R11", "carried delay count", 64'(slotCount), 1);
    checkEq("R11", "carried inst", 64'(slotInst[31:0]), 64'(lineWord(4)));
    checkEq("R11", "carried newPc", 64'(newPc), 64'h200);
    checkEq("R11", "carried newNpc", 64'(newNpc), 64'h204);
    delayMode = 1'b0;
  endtask

  task automatic testFault();
    clearBranch();
    doFetch(32'h104, 32'h108, 1'b1);
    checkEq("R12", "faultOut", 64'(faultOut), 1);
    checkEq("R12", "fault count", 64'(slotCount), 1);
    checkEq("R12", "fault inst", 64'(slotInst[31:0]), 64'(NOP));
    checkEq("R12", "fault newPc", 64'(newPc), 64'h104);
    checkEq("R12", "fault newNpc", 64'(newNpc), 64'h108);
    doFetch(32'h300, 32'h304, 1'b1);
    checkEq("R12", "fault beats miss", 64'(cacheReq), 0);
    checkEq("R12", "fault on miss flag", 64'(faultOut), 1);
  endtask

  task automatic testOtherBlockMiss();
    doFetch(32'h13C, 32'h140, 1'b0);
    checkEq("R3", "other-block cacheReq", 64'(cacheReq), 1);
    checkEq("R3", "other-block reqAddr", 64'(cacheReqAddr), 64'h120);
    checkEq("R3", "other-block count", 64'(slotCount), 0);
    checkEq("R3", "other-block newNpc", 64'(newNpc), 64'h140);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testColdMiss();
    doFill();
    testSequential();
    testLineEnd();
    testOffset();
    testTakenNoDelay();
    testNotTaken();
    testDelaySlot();
    testFault();
    testOtherBlockMiss();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule